// File: doc/BRIEF.md
# Floating-Point Format Converter

This block translates 32-bit floating-point words between two encodings. The first is IEEE-754 single precision: a sign bit, a biased exponent and a sign-magnitude fraction with an implied leading one. The second packs a 24-bit two's-complement fraction in the upper bits and an 8-bit two's-complement exponent in the low byte. It has no implied bit and no separate sign. Its fraction reads as a value in [-1, 1), with the top bit weighted 2^0.

A word is presented with a valid strobe and a direction select. The converted word appears two clock edges later, with its own valid strobe and three status flags: invalid input, overflow and underflow. Input fields are unpacked, the hidden bit is inserted or removed, and the sign representation is changed. Fractions are renormalized and exponents re-biased. The block performs no arithmetic on the values and never produces denormal results.

Top module: `fpc_convert`

## Requirements
- R1: A word sampled with `in_valid` high at clock edge N appears on the outputs with `out_valid` high after edge N+2. Without `in_valid`, `out_valid` is low two edges later. A synchronous active-high reset clears `out_valid`.
- R2: With `in_dir` = 0 (IEEE to two's complement), a normal input with sign s, biased exponent e and fraction f yields fraction 0.1f in bits 31..8, negated when s = 1. Bits 30..8 hold 1 followed by f[22:1], and f[0] is dropped by truncation. Bits 7..0 hold e-127+1 as 8-bit two's complement.
- R3: With `in_dir` = 0, a negative normal input whose f[22:1] is zero produces fraction 0x800000 (-1.0) with exponent e-127. No flag is set, including at e = 254.
- R4: With `in_dir` = 0, an input with exponent 255 and a nonzero fraction yields an all-zero word with the invalid flag set.
- R5: With `in_dir` = 0, an infinity, or a result exponent above +127, saturates to 0x7FFFFF7F for positive inputs or 0x8000007F for negative ones. The overflow flag is set.
- R6: A zero input in either direction (IEEE exponent and fraction zero, or two's-complement fraction zero with any exponent) yields an all-zero word with no flag. An IEEE input with exponent 0 and nonzero fraction yields zero with the underflow flag set.
- R7: With `in_dir` = 1 (two's complement to IEEE), a nonzero fraction F with exponent E converts as follows. The sign is bit 31, and the magnitude |F| is taken over 24 bits. If |F| has z leading zeros, the biased exponent is E-z+127 and the stored fraction is the 23 bits below the leading one. The conversion is exact.
- R8: With `in_dir` = 1, a biased exponent of 0 or less yields an all-zero word with the underflow flag set. A biased exponent of exactly 1 converts normally.
- R9: At most one of the three flags is high for any result. The flags are ordered invalid, overflow, underflow.
- R10: Every nonzero two's-complement result has bit 31 different from bit 30. Every IEEE result has an exponent field other than 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_dir | input | 1 | 0: IEEE to two's complement, 1: two's complement to IEEE |
| in_word | input | 32 | Word to convert |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 32 | Converted word |
| out_invalid | output | 1 | Input was not a number |
| out_overflow | output | 1 | Result saturated |
| out_underflow | output | 1 | Result flushed to zero |

## Verification
Two rules act on the same word in one cycle: the -1.0 renormalization and the exponent range check. The bench targets the inputs where they meet. A negative input at the top exponent with f[22:1] zero must lower the exponent to +127 and raise no flag. The same input with any higher fraction bit set must saturate with overflow. Because f[0] is truncated before the check, an input with only f[0] set must behave as the renormalizing case. Both words are sent back to back, mixed with opposite-direction traffic, and the scoreboard compares word, flags and latency for each.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
   typedef enum logic {
      DIR_TO_TC   = 1'b0,
      DIR_TO_IEEE = 1'b1
   } dir_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
   } flags_t;
endpackage

// File: rtl/fpc_ieee2tc.sv
`timescale 1ns/1ps
module fpc_ieee2tc
   import fpc_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic [W-1:0] src,
   output logic [W-1:0] dst,
   output flags_t       flg
);
   localparam int MW = FW + 1;
   localparam int XW = EW + 3;
   localparam logic signed [XW-1:0] BIAS_M1 = XW'(2**(EW-1) - 2);
   localparam logic signed [XW-1:0] ONE     = XW'(1);
   localparam logic signed [XW-1:0] EXP_HI  = XW'(2**(EW-1) - 1);
   localparam logic signed [XW-1:0] EXP_LO  = XW'(-(2**(EW-1)));
   localparam logic [EW-1:0]        EXP_SAT = {1'b0, {(EW-1){1'b1}}};

   logic                 sgn;
   logic [EW-1:0]        bexp;
   logic [FW-1:0]        frc;
   logic [MW-1:0]        mag;
   logic [MW-1:0]        tcf;
   logic signed [XW-1:0] tce;

   assign sgn  = src[W-1];
   assign bexp = src[W-2:FW];
   assign frc  = src[FW-1:0];
   // 1.f halved to 0.1f; the last stored bit falls off (truncation)
   assign mag  = {2'b01, frc[FW-1:1]};

   always_comb begin
      dst = '0;
      flg = '0;
      tcf = sgn ? (~mag + 1'b1) : mag;
      tce = signed'({3'b000, bexp}) - BIAS_M1;
      // -0.5 keeps sign and lead bit equal: move to -1.0, one exponent lower
      if (sgn && (frc[FW-1:1] == '0)) begin
         tcf = {1'b1, {(MW-1){1'b0}}};
         tce = tce - ONE;
      end
      if (bexp == '1) begin
         if (frc != '0) begin
            flg.invalid = 1'b1;
         end else begin
            flg.overflow = 1'b1;
            dst = {sgn, {(MW-1){~sgn}}, EXP_SAT};
         end
      end else if (bexp == '0) begin
         flg.underflow = (frc != '0);
      end else if (tce > EXP_HI) begin
         flg.overflow = 1'b1;
         dst = {sgn, {(MW-1){~sgn}}, EXP_SAT};
      end else if (tce < EXP_LO) begin
         flg.underflow = 1'b1;
      end else begin
         dst = {tcf, tce[EW-1:0]};
      end
   end
endmodule

// File: rtl/fpc_tc2ieee.sv
`timescale 1ns/1ps
module fpc_tc2ieee
   import fpc_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic [W-1:0] src,
   output logic [W-1:0] dst,
   output flags_t       flg
);
   localparam int MW = FW + 1;
   localparam int XW = EW + 3;
   localparam int LW = $clog2(MW + 1);
   localparam logic signed [XW-1:0] BIAS   = XW'(2**(EW-1) - 1);
   localparam logic signed [XW-1:0] BE_TOP = XW'(2**EW - 1);
   localparam logic signed [XW-1:0] ZERO   = '0;

   logic                 sgn;
   logic [MW-1:0]        tcf;
   logic [MW-1:0]        mag;
   logic signed [EW-1:0] tce;
   logic [LW-1:0]        lz;
   logic                 seen;
   logic [MW-2:0]        nrm;
   logic signed [XW-1:0] be;

   assign tcf = src[W-1:EW];
   assign tce = src[EW-1:0];
   assign sgn = tcf[MW-1];
   assign mag = sgn ? (~tcf + 1'b1) : tcf;

   // leading-zero count of the magnitude
   always_comb begin
      lz   = '0;
      seen = 1'b0;
      for (int i = MW - 1; i >= 0; i--) begin
         if (mag[i])     seen = 1'b1;
         else if (!seen) lz   = lz + 1'b1;
      end
   end

   assign nrm = (MW-1)'(mag << lz);
   assign be  = XW'(tce) - signed'(XW'(lz)) + BIAS;

   always_comb begin
      dst = '0;
      flg = '0;
      if (tcf != '0) begin
         if (be <= ZERO) begin
            flg.underflow = 1'b1;
         end else if (be >= BE_TOP) begin
            flg.overflow = 1'b1;
            dst = {sgn, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
         end else begin
            dst = {sgn, be[EW-1:0], nrm};
         end
      end
   end
endmodule

// File: rtl/fpc_convert.sv
`timescale 1ns/1ps
module fpc_convert
   import fpc_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         in_dir,
   input  logic [W-1:0] in_word,
   output logic         out_valid,
   output logic [W-1:0] out_word,
   output logic         out_invalid,
   output logic         out_overflow,
   output logic         out_underflow
);
   if (EW < 3 || FW < 4) begin : g_bad_widths
      $error("fpc_convert: exponent width must be >= 3 and fraction width >= 4");
   end
   if ($clog2(FW + 2) >= EW + 1) begin : g_bad_ratio
      $error("fpc_convert: fraction too wide for the exponent datapath");
   end

   logic         v1, v2;
   dir_e         d1, d2;
   logic [W-1:0] w1, w2;
   flags_t       f2;
   logic [W-1:0] tc_w, ie_w;
   flags_t       tc_f, ie_f;

   fpc_ieee2tc #(.EW(EW), .FW(FW)) u_to_tc (
      .src (w1),
      .dst (tc_w),
      .flg (tc_f)
   );

   fpc_tc2ieee #(.EW(EW), .FW(FW)) u_to_ieee (
      .src (w1),
      .dst (ie_w),
      .flg (ie_f)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
      end
   end

   always_ff @(posedge clk) begin
      w1 <= in_word;
      d1 <= dir_e'(in_dir);
      d2 <= d1;
      if (d1 == DIR_TO_IEEE) begin
         w2 <= ie_w;
         f2 <= ie_f;
      end else begin
         w2 <= tc_w;
         f2 <= tc_f;
      end
   end

   assign out_valid     = v2;
   assign out_word      = w2;
   assign out_invalid   = f2.invalid;
   assign out_overflow  = f2.overflow;
   assign out_underflow = f2.underflow;

   AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid); // R1
   AST_NO_GHOST: assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##2 !out_valid); // R1
   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && out_invalid) |-> (out_word == '0 && d2 == DIR_TO_TC)); // R4
   AST_SAT_EXP: assert property (@(posedge clk) disable iff (rst) (out_valid && out_overflow && d2 == DIR_TO_TC) |-> (out_word[EW-1:0] == {1'b0, {(EW-1){1'b1}}})); // R5
   AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst) (in_valid && in_word == '0) |-> ##2 (out_word == '0 && f2 == '0)); // R6
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst) out_valid |-> ($countones({out_invalid, out_overflow, out_underflow}) <= 1)); // R9
   AST_TC_NORM: assert property (@(posedge clk) disable iff (rst) (out_valid && d2 == DIR_TO_TC && out_word != '0) |-> (out_word[W-1] != out_word[W-2])); // R10
   AST_IEEE_FINITE: assert property (@(posedge clk) disable iff (rst) (out_valid && d2 == DIR_TO_IEEE) |-> (out_word[W-2:FW] != '1)); // R10
endmodule

// File: tb/fpc_convert_test.sv
`timescale 1ns/1ps
module fpc_convert_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_dir = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_invalid, out_overflow, out_underflow;

   typedef struct {
      logic [31:0] w;
      logic [2:0]  f;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fpc_convert uut (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .in_dir        (in_dir),
      .in_word       (in_word),
      .out_valid     (out_valid),
      .out_word      (out_word),
      .out_invalid   (out_invalid),
      .out_overflow  (out_overflow),
      .out_underflow (out_underflow)
   );

   // flags are {invalid, overflow, underflow}
   task automatic send(input logic [31:0] w, input logic d, input logic [31:0] ew,
                       input logic [2:0] ef, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_dir   = d;
      in_word  = w;
      sb.push_back('{ew, ef, cyc, tag});
      pushed++;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_word  = 32'hDEAD_BEEF;
      end
   endtask

   // monitor: pops the scoreboard whenever a result is valid
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected result: actual %h expected none", out_word);
         end else begin
            exp_t e;
            e = sb.pop_front();
            popped++;
            if (out_word !== e.w || {out_invalid, out_overflow, out_underflow} !== e.f
                || (cyc - e.cyc) != 2) begin
               errors++;
               $display("FAIL %s: actual %h flags %b lat %0d expected %h flags %b lat 2",
                        e.tag, out_word, {out_invalid, out_overflow, out_underflow},
                        cyc - e.cyc, e.w, e.f);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset valid: actual %b expected 0", out_valid);
      end
      rst = 1'b0;
      idle(2);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 idle after reset: actual %b expected 0", out_valid);
      end

      // IEEE -> two's complement
      send(32'h3F80_0000, 1'b0, 32'h4000_0001, 3'b000, "R2 R10 +1.0");
      send(32'h3FC0_0000, 1'b0, 32'h6000_0001, 3'b000, "R2 +1.5");
      send(32'hBFC0_0000, 1'b0, 32'hA000_0001, 3'b000, "R2 R10 -1.5");
      send(32'h3F80_0001, 1'b0, 32'h4000_0001, 3'b000, "R2 truncation");
      send(32'h3E80_0000, 1'b0, 32'h4000_00FF, 3'b000, "R2 +0.25");
      send(32'h0080_0000, 1'b0, 32'h4000_0083, 3'b000, "R2 smallest normal");
      send(32'hBF80_0000, 1'b0, 32'h8000_0000, 3'b000, "R3 -1.0");
      send(32'hBF80_0001, 1'b0, 32'h8000_0000, 3'b000, "R3 -1.0 truncated lsb");
      idle(1);
      send(32'hFF00_0000, 1'b0, 32'h8000_007F, 3'b000, "R3 top exponent renorm");
      send(32'hFF40_0000, 1'b0, 32'h8000_007F, 3'b010, "R5 top exponent negative");
      send(32'hFF00_0001, 1'b0, 32'h8000_007F, 3'b000, "R3 top exponent lsb only");
      send(32'h7F00_0000, 1'b0, 32'h7FFF_FF7F, 3'b010, "R5 top exponent positive");
      send(32'h7F80_0000, 1'b0, 32'h7FFF_FF7F, 3'b010, "R5 +inf");
      send(32'hFF80_0000, 1'b0, 32'h8000_007F, 3'b010, "R5 -inf");
      send(32'h7FC0_0000, 1'b0, 32'h0000_0000, 3'b100, "R4 nan");
      send(32'hFF80_0001, 1'b0, 32'h0000_0000, 3'b100, "R4 nan lsb");
      send(32'h0000_0000, 1'b0, 32'h0000_0000, 3'b000, "R6 +0");
      send(32'h8000_0000, 1'b0, 32'h0000_0000, 3'b000, "R6 -0");
      send(32'h0000_0001, 1'b0, 32'h0000_0000, 3'b001, "R6 denormal");
      send(32'h807F_FFFF, 1'b0, 32'h0000_0000, 3'b001, "R6 negative denormal");
      idle(3);

      // two's complement -> IEEE, interleaved with the other direction
      send(32'h4000_0001, 1'b1, 32'h3F80_0000, 3'b000, "R7 +1.0");
      send(32'hBFC0_0000, 1'b0, 32'hA000_0001, 3'b000, "R2 R9 mixed direction");
      send(32'h8000_0000, 1'b1, 32'hBF80_0000, 3'b000, "R7 -1.0");
      send(32'hA000_0001, 1'b1, 32'hBFC0_0000, 3'b000, "R7 -1.5");
      send(32'h0000_0105, 1'b1, 32'h3680_0000, 3'b000, "R7 unnormalized");
      send(32'h7FFF_FF7F, 1'b1, 32'h7EFF_FFFE, 3'b000, "R7 R10 largest");
      send(32'hFFFF_FF00, 1'b1, 32'hB400_0000, 3'b000, "R7 minus one lsb");
      idle(2);
      send(32'h0000_0000, 1'b1, 32'h0000_0000, 3'b000, "R6 tc zero");
      send(32'h0000_00FF, 1'b1, 32'h0000_0000, 3'b000, "R6 tc zero any exponent");
      send(32'h0000_0180, 1'b1, 32'h0000_0000, 3'b001, "R8 deep underflow");
      send(32'h4000_0083, 1'b1, 32'h0080_0000, 3'b000, "R8 boundary normal");
      send(32'h4000_0082, 1'b1, 32'h0000_0000, 3'b001, "R8 boundary underflow");
      idle(6);

      checks++;
      if (sb.size() != 0 || pushed != popped) begin
         errors++;
         $display("FAIL R1 results missing: actual %0d expected %0d", popped, pushed);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule